// File: doc/BRIEF.md
# Write-Only Serial Control Register Loader

This block is an I2C slave receiver that loads a small bank of clock-control registers. It runs on a system clock that is much faster than the serial clock and oversamples the two bus wires. It detects the START and STOP conditions and compares the first byte of a transfer against a fixed 8-bit device byte. Every byte it accepts is acknowledged by driving the data line low for the ninth bit.

Sub-addressing is not supported. After the device byte, the master must send two filler bytes: a command code and a byte count. Both are acknowledged and then discarded. The data bytes that follow load the registers in order, starting from register 0 on every transfer. So a master that wants to change one register must resend every register below it.

The bus side consists of an SCL input, an SDA input and an active-high drive-low enable for an open-drain pad. The register side is a flat parallel output. The registers keep their contents between transfers, and only the synchronous reset restores the power-up values.

Top module: `clkctl_i2c_slave`

## Requirements
- R1: After reset the registers hold these values: index 0 = 0x0C, 1 = 0x1F, 2 = 0x7F, 3 = 0xFF, 4 = 0xFF, 5 = 0x71, 6 = 0x00. Register n occupies `regs_o[8n+7:8n]`. The SDA drive enable is 0.
- R2: A falling SDA while SCL is high is a START and begins reception of the device byte. A rising SDA while SCL is high is a STOP and returns the slave to idle with SDA released.
- R3: Bits are sampled on SCL rising edges, MSB first. Only the device byte 0xD2 (7-bit address 0x69 with a write bit of 0 in the LSB) is acknowledged. Any other value, 0xD3 included, gets no acknowledge, and the slave ignores the bus until the next START.
- R4: The two bytes that follow the device byte are always acknowledged, and their contents never change any register.
- R5: The k-th data byte (k counting from 0) is acknowledged and written to register k. Data bytes with k from 7 to 9 are acknowledged but not stored.
- R6: At most 10 data bytes are acknowledged per transfer. The 11th is neither acknowledged nor written, and the slave then ignores the bus until the next START.
- R7: Registers keep their values across transfers. A transfer that carries k data bytes changes only registers 0 to k-1.
- R8: The acknowledge drive turns on while SCL is low, after the falling edge that ends the 8th bit. It turns off on the falling edge that ends the acknowledge bit. The drive enable never changes while SCL is high.
- R9: A START in the middle of a byte abandons that byte and restarts reception at the device byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset, loads the power-up values |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls the SDA line low (open-drain drive) |
| regs_o | output | REG_COUNT*8 | Register bank, register n in bits 8n+7 to 8n |

## Verification
The bench goes after the limits of the data count. A transfer of 11 data bytes checks that the last one is refused and left unwritten; a counter off by one would acknowledge or store it. Bytes 7 to 9 must be acknowledged yet leave registers 0 to 6 alone; a design that wrapped the register index would overwrite low registers with them.

Device bytes 0xD3 and random non-matching values are sent to catch a decoder that ignores the R/W bit. A transfer carrying only the two filler bytes exposes any design that stores the command code. A START placed inside a partial byte shows whether the bit counter is really cleared, because a stale count would misalign the next device byte so it is never acknowledged. A monitor also watches the drive enable, since an acknowledge released late, after SCL rises, would create a false STOP or START on the bus.

// File: rtl/clkctl_i2c_pkg.sv
// Shared types and power-up values for the serial control register loader.
package clkctl_i2c_pkg;

    // Receiver states: idle, shifting a byte, waiting for the 8th-bit
    // falling edge, driving the acknowledge bit.
    typedef enum logic [1:0] {
        RX_IDLE      = 2'd0,
        RX_BITS      = 2'd1,
        RX_ACK_WAIT  = 2'd2,
        RX_ACK_DRIVE = 2'd3
    } rx_state_e;

    // Number of filler bytes that follow the device byte.
    localparam int PREAMBLE_BYTES = 2;

    // Power-up value of register idx: only the defined enable bits are set.
    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h0C;
            1:       return 8'h1F;
            2:       return 8'h7F;
            3:       return 8'hFF;
            4:       return 8'hFF;
            5:       return 8'h71;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronises SCL and SDA into the system clock domain and derives SCL
// edges plus START and STOP strobes.
// Assumes the system clock is at least several times faster than SCL.
// Both lines reset to the idle-high level.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // Synchronizer stages plus one extra stage that holds the previous level.
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;
    logic scl_prev;
    logic sda_prev;

    // Shift both bus lines through the synchronizer and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
        end
    end

    // Decode levels, edges and bus conditions from the current and previous samples.
    always_comb begin
        scl_lvl   = scl_pipe[SYNC_STAGES-1];
        sda_lvl   = sda_pipe[SYNC_STAGES-1];
        scl_prev  = scl_pipe[SYNC_STAGES];
        sda_prev  = sda_pipe[SYNC_STAGES];
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

    // R2: a bus condition is only ever flagged while SCL stays high.
    a_r2_cond_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |-> $past(scl_lvl));

endmodule

// File: rtl/i2c_wr_fsm.sv
// Byte receiver and transfer sequencer for the write-only slave.
// It shifts bits on SCL rising edges, acknowledges accepted bytes and
// issues one write strobe per stored data byte.
// Assumes SDA is stable while SCL is high, except during START and STOP.
module i2c_wr_fsm
    import clkctl_i2c_pkg::*;
#(
    parameter logic [7:0] DEV_BYTE  = 8'hD2,
    parameter int         REG_COUNT = 7,
    parameter int         MAX_DATA  = 10,
    localparam int        IDX_W     = $clog2(MAX_DATA + PREAMBLE_BYTES + 2),
    localparam int        RIDX_W    = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [RIDX_W-1:0] wr_idx,
    output logic [7:0]        wr_data
);
    localparam logic [IDX_W-1:0] FIRST_DATA = IDX_W'(PREAMBLE_BYTES + 1);

    rx_state_e          state;
    logic [2:0]         bit_cnt;
    logic [6:0]         shreg;
    logic [IDX_W-1:0]   byte_idx;
    logic [IDX_W-1:0]   data_idx;
    logic [7:0]         full_byte;
    logic               byte_done;
    logic               accept_c;
    logic               store_c;

    // Classify the byte that completes on this SCL rising edge.
    always_comb begin
        full_byte = {shreg, sda_lvl};
        data_idx  = byte_idx - FIRST_DATA;
        byte_done = (state == RX_BITS) && scl_rise && (bit_cnt == 3'd7);
        if (byte_idx == '0)
            accept_c = (full_byte == DEV_BYTE);
        else if (byte_idx < FIRST_DATA)
            accept_c = 1'b1;
        else
            accept_c = (data_idx < IDX_W'(MAX_DATA));
        store_c = (byte_idx >= FIRST_DATA) && (data_idx < IDX_W'(REG_COUNT));
        wr_en   = byte_done && accept_c && store_c;
        wr_idx  = RIDX_W'(data_idx);
        wr_data = full_byte;
    end

    // Sequence bits, acknowledge bits and the byte position within a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_idx <= '0;
            sda_oe   <= 1'b0;
        end else if (start_det) begin
            state    <= RX_BITS;
            bit_cnt  <= '0;
            byte_idx <= '0;
            sda_oe   <= 1'b0;
        end else if (stop_det) begin
            state    <= RX_IDLE;
            sda_oe   <= 1'b0;
        end else begin
            case (state)
                RX_BITS: if (scl_rise) begin
                    shreg   <= full_byte[6:0];
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7)
                        state <= accept_c ? RX_ACK_WAIT : RX_IDLE;
                end
                RX_ACK_WAIT: if (scl_fall) begin
                    sda_oe <= 1'b1;
                    state  <= RX_ACK_DRIVE;
                end
                RX_ACK_DRIVE: if (scl_fall) begin
                    sda_oe   <= 1'b0;
                    bit_cnt  <= '0;
                    byte_idx <= byte_idx + IDX_W'(1);
                    state    <= RX_BITS;
                end
                default: ;
            endcase
        end
    end

    // R2, R9: a START always restarts reception at bit 0 of the device byte.
    a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == RX_BITS) && (bit_cnt == 3'd0) && (byte_idx == '0));

    // R2: a STOP leaves the slave idle with the line released.
    a_r2_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == RX_IDLE) && !sda_oe);

    // R8: the acknowledge drive switches on only while SCL is low.
    a_r8_oe_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    // R8: the drive switches off only while SCL is low, or on a bus condition.
    a_r8_oe_off_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> (!scl_lvl || $past(start_det || stop_det)));

    // R6: nothing is written once the data-byte limit has been reached.
    a_r6_no_write_past_limit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (byte_idx < IDX_W'(MAX_DATA) + FIRST_DATA));

endmodule

// File: rtl/ctl_regbank.sv
// Bank of 8-bit control registers written one at a time by index.
// Each register resets to its power-up value; nothing else clears it.
module ctl_regbank
    import clkctl_i2c_pkg::*;
#(
    parameter int  REG_COUNT = 7,
    localparam int RIDX_W    = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [RIDX_W-1:0]      wr_idx,
    input  logic [7:0]             wr_data,
    output logic [REG_COUNT*8-1:0] regs
);
    genvar g;
    generate
        for (g = 0; g < REG_COUNT; g++) begin : g_reg
            // Hold one register and load it when its index is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[g*8 +: 8] <= reg_default(g);
                else if (wr_en && (wr_idx == RIDX_W'(g)))
                    regs[g*8 +: 8] <= wr_data;
            end
        end
    endgenerate

    // R5: the sequencer never presents an index outside the bank.
    a_r5_idx_in_bank: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < RIDX_W'(REG_COUNT)));

    // R7: without a write strobe the bank keeps its contents.
    a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));

endmodule

// File: rtl/clkctl_i2c_slave.sv
// Top of the write-only serial control register loader.
// It joins the line synchronizer, the byte sequencer and the register bank.
// Assumes an open-drain pad outside the block: sda_oe_o = 1 pulls SDA low.
module clkctl_i2c_slave #(
    parameter logic [7:0] DEV_BYTE    = 8'hD2,
    parameter int         REG_COUNT   = 7,
    parameter int         MAX_DATA    = 10,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    output logic [REG_COUNT*8-1:0] regs_o
);
    localparam int RIDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [RIDX_W-1:0] wr_idx;
    logic [7:0]        wr_data;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    i2c_wr_fsm #(.DEV_BYTE(DEV_BYTE), .REG_COUNT(REG_COUNT), .MAX_DATA(MAX_DATA)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .sda_oe(sda_oe_o), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data)
    );

    ctl_regbank #(.REG_COUNT(REG_COUNT)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .regs(regs_o)
    );

endmodule

// File: tb/tb_clkctl_i2c_slave.sv
// Self-checking bench: a bus master model with directed and random transfers.
module tb_clkctl_i2c_slave;
    localparam int NREG = 7;
    localparam int Q    = 6;   // system clocks per quarter SCL period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] regs;
    wire  sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int fails = 0;
    int oe_viol = 0;
    int oe_rises = 0;
    bit done = 1'b0;
    logic prev_oe = 1'b0;
    logic [7:0] exp_regs [NREG];
    logic [7:0] tx [16];

    clkctl_i2c_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .regs_o(regs)
    );

    always #5 clk = ~clk;

    // R8 monitor: the drive enable may only change while SCL is low.
    always @(negedge clk) begin
        if (rst_n && sda_oe !== prev_oe) begin
            if (scl_m) oe_viol++;
            if (sda_oe) oe_rises++;
        end
        prev_oe = sda_oe;
    end

    function automatic logic [7:0] dflt(input int i);
        case (i)
            0: return 8'h0C; 1: return 8'h1F; 2: return 8'h7F;
            3: return 8'hFF; 4: return 8'hFF; 5: return 8'h71;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit data_acked(input int k);
        return k < 10;
    endfunction

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic check_regs(input string tag);
        for (int r = 0; r < NREG; r++)
            chk(regs[r*8 +: 8] === exp_regs[r], tag, 32'(regs[r*8 +: 8]), 32'(exp_regs[r]));
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_q(1); sda_m = 1'b0;
        wait_q(1); scl_m = 1'b1;
        wait_q(1); sda_m = 1'b1;
        wait_q(1);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            wait_q(1); sda_m = b[i];
            wait_q(1); scl_m = 1'b1;
            wait_q(2); scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        wait_q(1); sda_m = 1'b1;
        wait_q(1); scl_m = 1'b1;
        wait_q(1); acked = (sda_bus == 1'b0);
        wait_q(1); scl_m = 1'b0;
    endtask

    // One full transfer: device byte, two filler bytes, n data bytes from tx[].
    task automatic xfer(input logic [7:0] dev, input int n);
        bit a;
        bit exp_a;
        bus_start();
        send_byte(dev, a);
        exp_a = (dev == 8'hD2);
        chk(a == exp_a, "R3 device byte ack", 32'(a), 32'(exp_a));
        if (exp_a) begin
            for (int p = 0; p < 2; p++) begin
                send_byte(8'($urandom), a);
                chk(a == 1'b1, "R4 filler byte ack", 32'(a), 32'd1);
            end
            for (int k = 0; k < n; k++) begin
                send_byte(tx[k], a);
                chk(a == data_acked(k), data_acked(k) ? "R5 data ack" : "R6 limit nack",
                    32'(a), 32'(data_acked(k)));
                if (!data_acked(k)) break;
                if (k < NREG) exp_regs[k] = tx[k];
            end
        end
        bus_stop();
        wait_q(1);
        check_regs("R7 register contents after transfer");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        bit a;
        void'($urandom(32'h5EED_0674));
        for (int r = 0; r < NREG; r++) exp_regs[r] = dflt(r);
        repeat (4) @(negedge clk);
        // R1: power-up values and released line.
        check_regs("R1 reset value");
        chk(sda_oe == 1'b0, "R1 drive released in reset", 32'(sda_oe), 32'd0);
        rst_n = 1'b1;
        wait_q(2);
        check_regs("R1 value after reset release");

        // R5, R7: two data bytes touch only registers 0 and 1.
        tx[0] = 8'hA5; tx[1] = 8'h3C;
        xfer(8'hD2, 2);

        // R4: filler bytes alone change nothing.
        xfer(8'hD2, 0);

        // R3: read byte and a wrong device byte are refused.
        tx[0] = 8'h00;
        xfer(8'hD3, 3);
        xfer(8'h52, 3);

        // R5, R6: 11 data bytes; bytes 7..9 acked not stored, 11th refused.
        for (int k = 0; k < 11; k++) tx[k] = 8'(8'h10 + k);
        xfer(8'hD2, 11);

        // R9: START inside a partial device byte restarts address reception.
        bus_start();
        send_bits(8'hD2, 5);
        tx[0] = 8'h99;
        xfer(8'hD2, 1);

        // R9: START inside a partial data byte discards it.
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_bits(8'h0F, 4);
        tx[0] = 8'h42; tx[1] = 8'h24;
        xfer(8'hD2, 2);

        // R2, R7: a STOP with no data and the bus left idle keeps registers.
        bus_start();
        bus_stop();
        wait_q(1);
        check_regs("R2 stop returns to idle, registers kept");

        // Random transfers mixed over device bytes and data counts.
        for (int t = 0; t < 22; t++) begin
            logic [7:0] dev;
            int n;
            dev = ($urandom % 4 == 0) ? 8'($urandom) : 8'hD2;
            n = $urandom % 12;
            for (int k = 0; k < 12; k++) tx[k] = 8'($urandom);
            xfer(dev, n);
        end

        // R8: acknowledges were driven and never toggled with SCL high.
        chk(oe_viol == 0, "R8 drive changed while SCL high", 32'(oe_viol), 32'd0);
        chk(oe_rises > 0, "R8 acknowledge drive seen", 32'(oe_rises), 32'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule